// File: doc/BRIEF.md
# Driver Fault Supervisor

This block watches the protection flags around a set of power switches and decides when every driver must be switched off. It takes one current-limit flag for each switch, a thermal flag, an undervoltage flag and a power-on indication. From these it drives one global driver-off line, a reset line for the control registers and logic around it, and a small status word that records which fault caused the shutdown. The analog comparators that raise the flags live elsewhere. The flags arrive here as raw levels and pass through a synchronizer first.

A current limit is a fault only when it lasts. Short limit events are ignored. A limit condition that stays active on at least one switch for longer than a qualify time, counted in clock cycles, latches an overcurrent shutdown. An overcurrent or thermal shutdown stays latched until the supply is cycled. Here a supply cycle means the undervoltage flag, or the power-on indication, going active and then releasing. Undervoltage itself latches nothing. While it lasts, the drivers are off and the control logic is held in reset. When the supply comes back, operation resumes without help.

Top module: `fault_supervisor`

## Requirements
- R1: Synchronous reset `rst` clears both latched faults. While reset is held, `drv_off_o` and `ctl_rst_o` read 1 and `fault_stat_o` reads 0. With no fault present, both lines read 0 one clock after reset is released.
- R2: `fault_stat_o` bit 0 marks an overcurrent. It is set, together with `drv_off_o`, when the OR of the synchronized `ilim_i` flags has been 1 on QUAL_CYC+1 consecutive clock edges. A flag that goes high before edge 1 and stays high latches the fault on edge SYNC_STAGES+QUAL_CYC+1.
- R3: A limit condition seen on QUAL_CYC edges or fewer latches nothing. Any edge on which no flag is active restarts the count.
- R4: Flags on different switches that overlap in time count as one unbroken condition, even when the active switch changes.
- R5: A latched overcurrent stays set after the flags clear. It is cleared only on the edge where a supply cycle releases, which is SYNC_STAGES+1 edges after the releasing input changes.
- R6: `fault_stat_o` bit 1 marks overtemperature. It and `drv_off_o` are set SYNC_STAGES+1 edges after `hot_i` rises.
- R7: A latched overtemperature stays set after `hot_i` falls. It clears only when a supply cycle releases while the synchronized `hot_i` is 0. If `hot_i` is still high at the release, the latch stays set.
- R8: While `uv_i` is high, `fault_stat_o` bit 2, `ctl_rst_o` and `drv_off_o` are 1. The delay is SYNC_STAGES+1 edges in both directions. On release all three return to 0 without help, unless another fault is latched.
- R9: While the supply is down, current-limit flags are not counted. After the release, counting starts from zero.
- R10: `por_i` high acts like a supply down: `drv_off_o` and `ctl_rst_o` go to 1 and its release clears the latched faults, but `fault_stat_o` bit 2 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ilim_i | input | N_SW | Raw current-limit flag for each switch |
| hot_i | input | 1 | Raw overtemperature flag |
| uv_i | input | 1 | Raw supply undervoltage flag |
| por_i | input | 1 | Power-on indication; high while power is coming up |
| drv_off_o | output | 1 | Global disable for all drivers |
| ctl_rst_o | output | 1 | Reset for the control registers and logic |
| fault_stat_o | output | 3 | Bit 0 overcurrent (latched), bit 1 overtemperature (latched), bit 2 undervoltage (live) |

## Verification
Every result lags its stimulus by a fixed number of edges. Undervoltage, power-on and thermal changes show up SYNC_STAGES+1 edges after the input changes. A latched overcurrent shows up SYNC_STAGES+QUAL_CYC+1 edges after the first limit flag, and only if the condition is still present on the last of those edges. The bench drives inputs at the falling clock edge and holds each stimulus for an exact number of rising edges before it samples. Several rows sample one edge before and again on the edge where a result is due, so an early or late output fails a check.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Bit positions inside the status word
  localparam int FS_OC = 0;
  localparam int FS_OT = 1;
  localparam int FS_UV = 2;
  localparam int FS_W  = 3;

  typedef logic [FS_W-1:0] fstat_t;

  // Synchronized non-current environment flags
  typedef struct packed {
    logic por;
    logic uv;
    logic hot;
  } env_t;

endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[g] <= '0;
          else     st[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[g] <= '0;
          else     st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];

endmodule

// File: rtl/fsup_oc_qual.sv
module fsup_oc_qual #(
  parameter int N_SW = 8,
  parameter int QUAL = 300
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_SW-1:0] flags_s,
  input  logic            hold_clr,
  output logic            any_o,
  output logic            trip_o
);

  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL);

  logic [CW-1:0] cnt;

  assign any_o  = |flags_s;
  assign trip_o = any_o & ~hold_clr & (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (rst || hold_clr || !any_o) cnt <= '0;
    else if (cnt != CMAX)          cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fsup_recov.sv
module fsup_recov
  import fsup_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   oc_trip,
  input  env_t   env_s,
  output logic   down_o,
  output logic   drv_off_o,
  output logic   ctl_rst_o,
  output fstat_t stat_o
);

  logic down_q;
  logic release_w;
  logic oc_n, ot_n;

  assign down_o    = env_s.uv | env_s.por;
  assign release_w = down_q & ~down_o;

  // Latches: a new fault takes priority over a release on the same edge
  assign oc_n = oc_trip   | (stat_o[FS_OC] & ~release_w);
  assign ot_n = env_s.hot | (stat_o[FS_OT] & ~release_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      down_q    <= 1'b0;
      drv_off_o <= 1'b1;
      ctl_rst_o <= 1'b1;
      stat_o    <= '0;
    end else begin
      down_q        <= down_o;
      drv_off_o     <= down_o | oc_n | ot_n;
      ctl_rst_o     <= down_o;
      stat_o[FS_OC] <= oc_n;
      stat_o[FS_OT] <= ot_n;
      stat_o[FS_UV] <= env_s.uv;
    end
  end

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int N_SW        = 8,
  parameter int QUAL_CYC    = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_SW-1:0] ilim_i,
  input  logic            hot_i,
  input  logic            uv_i,
  input  logic            por_i,
  output logic            drv_off_o,
  output logic            ctl_rst_o,
  output logic [2:0]      fault_stat_o
);

  localparam int SW = N_SW + $bits(env_t);

  logic [SW-1:0]   raw_w, syn_w;
  logic [N_SW-1:0] ilim_s;
  env_t            env_s;
  logic            hot_s;
  logic            oc_any, oc_trip, sup_down;
  fstat_t          stat_w;

  assign raw_w  = {por_i, uv_i, hot_i, ilim_i};
  assign ilim_s = syn_w[N_SW-1:0];
  assign env_s  = env_t'(syn_w[SW-1:N_SW]);
  assign hot_s  = env_s.hot;

  fsup_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (raw_w),
    .q   (syn_w)
  );

  fsup_oc_qual #(.N_SW(N_SW), .QUAL(QUAL_CYC)) qual_i (
    .clk      (clk),
    .rst      (rst),
    .flags_s  (ilim_s),
    .hold_clr (sup_down),
    .any_o    (oc_any),
    .trip_o   (oc_trip)
  );

  fsup_recov recov_i (
    .clk       (clk),
    .rst       (rst),
    .oc_trip   (oc_trip),
    .env_s     (env_s),
    .down_o    (sup_down),
    .drv_off_o (drv_off_o),
    .ctl_rst_o (ctl_rst_o),
    .stat_o    (stat_w)
  );

  assign fault_stat_o = stat_w;

endmodule

// File: rtl/fsup_chk.sv
module fsup_chk #(
  parameter int QUAL_CYC = 300
) (
  input logic       clk,
  input logic       rst,
  input logic       drv_off_o,
  input logic       ctl_rst_o,
  input logic [2:0] fault_stat_o,
  input logic       oc_any,
  input logic       sup_down,
  input logic       hot_s
);

  localparam int RW = $clog2(QUAL_CYC + 2);
  localparam logic [RW-1:0] RMAX = RW'(QUAL_CYC + 1);

  // Run length of unbroken limit activity while the supply is up
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !oc_any || sup_down) run_q <= '0;
    else if (run_q != RMAX)         run_q <= run_q + 1'b1;
  end

  AST_OC_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_stat_o[0]) |-> ($past(run_q) >= RW'(QUAL_CYC)) && $past(oc_any)); // R2
  AST_OC_NOT_IN_DOWN: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_stat_o[0]) |-> !$past(sup_down)); // R9
  AST_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_stat_o[0]) |-> $fell(ctl_rst_o)); // R5
  AST_OT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_stat_o[1]) |-> $past(hot_s)); // R6
  AST_OT_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (fault_stat_o[1] || fault_stat_o[0]) |-> drv_off_o); // R6
  AST_OT_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_stat_o[1]) |-> $fell(ctl_rst_o)); // R7
  AST_UV_RESETS: assert property (@(posedge clk) disable iff (rst)
    fault_stat_o[2] |-> (ctl_rst_o && drv_off_o)); // R8
  AST_RST_OFF: assert property (@(posedge clk) disable iff (rst)
    ctl_rst_o |-> drv_off_o); // R10

endmodule

bind fault_supervisor fsup_chk #(.QUAL_CYC(QUAL_CYC)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .drv_off_o    (drv_off_o),
  .ctl_rst_o    (ctl_rst_o),
  .fault_stat_o (fault_stat_o),
  .oc_any       (oc_any),
  .sup_down     (sup_down),
  .hot_s        (hot_s)
);

// File: tb/fault_supervisor_tb_top.sv
module fault_supervisor_tb_top;

  localparam int N_SW = 4;
  localparam int QUAL = 8;
  localparam int SYNC = 2;

  typedef struct packed {
    logic [3:0] ilim;
    logic       hot;
    logic       uv;
    logic       por;
    logic [7:0] cyc;
    logic       drv;
    logic       crst;
    logic [2:0] st;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{4'b0000,1'b0,1'b0,1'b0,8'd5, 1'b0,1'b0,3'b000,8'd1},  // R1 idle
    '{4'b0001,1'b0,1'b0,1'b0,8'd8, 1'b0,1'b0,3'b000,8'd3},  // R3 QUAL-long pulse
    '{4'b0000,1'b0,1'b0,1'b0,8'd4, 1'b0,1'b0,3'b000,8'd3},  // R3 no trip
    '{4'b0010,1'b0,1'b0,1'b0,8'd9, 1'b0,1'b0,3'b000,8'd2},  // R2 QUAL+1 long
    '{4'b0000,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,3'b000,8'd2},  // R2 edge 10: not yet
    '{4'b0000,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b0,3'b001,8'd2},  // R2 edge 11: latched
    '{4'b0000,1'b0,1'b0,1'b0,8'd4, 1'b1,1'b0,3'b001,8'd5},  // R5 holds
    '{4'b0000,1'b0,1'b1,1'b0,8'd3, 1'b1,1'b1,3'b101,8'd8},  // R8 supply down
    '{4'b0000,1'b0,1'b0,1'b0,8'd2, 1'b1,1'b1,3'b101,8'd5},  // R5 release not yet
    '{4'b0000,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,3'b000,8'd5},  // R5 cleared
    '{4'b0100,1'b0,1'b0,1'b0,8'd5, 1'b0,1'b0,3'b000,8'd3},  // R3 gap test
    '{4'b0000,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,3'b000,8'd3},  // R3
    '{4'b0100,1'b0,1'b0,1'b0,8'd8, 1'b0,1'b0,3'b000,8'd3},  // R3
    '{4'b0000,1'b0,1'b0,1'b0,8'd4, 1'b0,1'b0,3'b000,8'd3},  // R3 restarted, no trip
    '{4'b0001,1'b0,1'b0,1'b0,8'd5, 1'b0,1'b0,3'b000,8'd4},  // R4 overlap
    '{4'b0011,1'b0,1'b0,1'b0,8'd2, 1'b0,1'b0,3'b000,8'd4},  // R4
    '{4'b0010,1'b0,1'b0,1'b0,8'd4, 1'b1,1'b0,3'b001,8'd4},  // R4 trips on edge 11
    '{4'b0000,1'b0,1'b0,1'b0,8'd3, 1'b1,1'b0,3'b001,8'd4},  // R4
    '{4'b0000,1'b0,1'b0,1'b1,8'd3, 1'b1,1'b1,3'b001,8'd10}, // R10 power-on down
    '{4'b0000,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,3'b000,8'd10}, // R10 release clears
    '{4'b0000,1'b1,1'b0,1'b0,8'd2, 1'b0,1'b0,3'b000,8'd6},  // R6 not yet
    '{4'b0000,1'b1,1'b0,1'b0,8'd1, 1'b1,1'b0,3'b010,8'd6},  // R6 latched
    '{4'b0000,1'b0,1'b0,1'b0,8'd3, 1'b1,1'b0,3'b010,8'd7},  // R7 holds
    '{4'b0000,1'b1,1'b0,1'b0,8'd3, 1'b1,1'b0,3'b010,8'd7},  // R7
    '{4'b0000,1'b1,1'b1,1'b0,8'd3, 1'b1,1'b1,3'b110,8'd7},  // R7 down while hot
    '{4'b0000,1'b1,1'b0,1'b0,8'd3, 1'b1,1'b0,3'b010,8'd7},  // R7 still hot at release
    '{4'b0000,1'b0,1'b0,1'b0,8'd3, 1'b1,1'b0,3'b010,8'd7},  // R7
    '{4'b0000,1'b0,1'b1,1'b0,8'd3, 1'b1,1'b1,3'b110,8'd7},  // R7
    '{4'b0000,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,3'b000,8'd7},  // R7 cleared
    '{4'b1111,1'b0,1'b1,1'b0,8'd12,1'b1,1'b1,3'b100,8'd9},  // R9 no count while down
    '{4'b1111,1'b0,1'b0,1'b0,8'd10,1'b0,1'b0,3'b000,8'd9},  // R9 count restarted
    '{4'b1111,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b0,3'b001,8'd9},  // R9 trips on edge 11
    '{4'b0000,1'b0,1'b1,1'b0,8'd3, 1'b1,1'b1,3'b101,8'd8},  // R8
    '{4'b0000,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,3'b000,8'd8}   // R8 recovered
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N_SW-1:0] ilim = '0;
  logic            hot = 1'b0, uv = 1'b0, por = 1'b0;
  logic            drv_off, ctl_rst;
  logic [2:0]      stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fault_supervisor #(.N_SW(N_SW), .QUAL_CYC(QUAL), .SYNC_STAGES(SYNC)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .ilim_i       (ilim),
    .hot_i        (hot),
    .uv_i         (uv),
    .por_i        (por),
    .drv_off_o    (drv_off),
    .ctl_rst_o    (ctl_rst),
    .fault_stat_o (stat)
  );

  task automatic check(input string tag, input logic [4:0] exp);
    n_chk++;
    if ({drv_off, ctl_rst, stat} !== exp) begin
      n_fail++;
      $display("FAIL %s: {drv_off,ctl_rst,stat} actual %b expected %b",
               tag, {drv_off, ctl_rst, stat}, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 in reset", 5'b11_000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 5'b00_000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      ilim = VECS[i].ilim;
      hot  = VECS[i].hot;
      uv   = VECS[i].uv;
      por  = VECS[i].por;
      repeat (int'(VECS[i].cyc)) @(negedge clk);
      check($sformatf("R%0d row %0d", VECS[i].req, i),
            {VECS[i].drv, VECS[i].crst, VECS[i].st});
    end

    // R1: reset clears a latched overcurrent
    ilim = 4'b1000;
    repeat (12) @(negedge clk);
    check("R2 before mid reset", 5'b10_001);
    ilim = '0;
    rst  = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mid reset", 5'b11_000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 latch cleared by reset", 5'b00_000);

    finish_up();
  end

endmodule